// File: doc/BRIEF.md
# Fractional Clock Enable with Kick Handshake

This block turns a fast input clock into a slower CPU-class clock by swallowing input pulses. Out of every window of 32 input cycles it lets exactly `mult` cycles through, where `mult` runs from 1 to 32. The output is a clock-enable that is registered once and meant to drive a downstream clock gate. The passing cycles are spread evenly across the window by a phase accumulator. Each cycle the accumulator adds `mult`, and it emits an enable whenever the sum reaches or passes 32.

Software programs the ratio through a small register port. A ratio register holds a 5-bit code in bits 12:8, and `mult` equals 32 minus that code. Writing the code changes nothing on its own. Software then sets bit 31 of the kick register to request the change. Hardware captures the code at that moment and applies it at the next 32-cycle window boundary. In the same cycle it clears the kick bit. Software polls that bit to learn that the new rate is in force. While the bit is set, the update is busy and any further kick request is ignored.

Top module: `frac_clk_kick`

## Requirements
- R1: After reset both registers read 0, `busy` is low, and the active ratio is mult = 32, so `clk_en` is high on every cycle.
- R2: With a steady code C (ratio register bits 12:8), any 32 consecutive cycles contain exactly 32 − C cycles with `clk_en` high.
- R3: Writing the ratio register alone leaves the active ratio unchanged.
- R4: Writing the kick register (address 1) with bit 31 set while idle raises `busy` on the next cycle, and bit 31 of the kick register then reads back as 1.
- R5: Hardware clears the kick bit and `busy` no more than 32 cycles after it was set.
- R6: A kick write made while `busy` is high is ignored. The code captured at the accepted kick is the one applied, and later ratio writes do not alter it.
- R7: The active ratio changes only at a 32-cycle window boundary. The 32 cycles that follow the cycle in which `busy` is seen low carry exactly the new mult enables.
- R8: All bits other than bit 31 of the kick register read back as written, in both registers, and are not changed by an update.
- R9: Whenever mult is 16 or more, `clk_en` is never low on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be swallowed |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 ratio, 1 kick |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| clk_en | output | 1 | Registered pulse-swallowed clock enable |
| busy | output | 1 | Kick pending; mirrors kick bit 31 |

## Verification
The assertions assume a single writer on the register port and one write per cycle at most. They also assume software does not rely on a kick launched in the same cycle as a ratio write picking up that new code. The bench keeps to this by spacing every write one full cycle apart. It waits for `busy` to drop, or deliberately probes the busy window, before it measures any rate. All pulse counts are taken over 32 whole cycles while the ratio is held steady.

// File: rtl/frc_pkg.sv
// Package: shared constants for the fractional clock block.
// Assumes a 32-bit register port with two decoded addresses.
package frc_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int WIN_W     = 5;               // window = 2**WIN_W cycles
    localparam int MULT_W    = WIN_W + 1;       // holds 1..2**WIN_W
    localparam int CODE_LSB  = 8;               // code field position
    localparam int KICK_BIT  = 31;              // self-clearing request bit
    localparam logic [ADDR_W-1:0] ADDR_RATIO = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_KICK  = 2'd1;
endpackage

// File: rtl/frc_regs.sv
// Module: register bank holding the ratio word and the kick word.
// The kick bit itself is owned by the update logic; this bank only
// raises a request when bit KICK_BIT is written as 1 while idle.
module frc_regs
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic [WIN_W-1:0]  code,
    output logic              kick_req
);
    logic [DATA_W-1:0] ratio_q;
    logic [DATA_W-1:0] kick_q;   // bit KICK_BIT unused here

    // Store software writes into the two words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= '0;
            kick_q  <= '0;
        end else if (we) begin
            if (addr == ADDR_RATIO) ratio_q <= wdata;
            if (addr == ADDR_KICK)  kick_q  <= wdata;
        end
    end

    // Decode a kick request and the current code field.
    always_comb begin
        kick_req = we && (addr == ADDR_KICK) && wdata[KICK_BIT] && !busy;
        code     = ratio_q[CODE_LSB +: WIN_W];
    end

    // Read mux; the kick bit reflects the hardware-owned busy state.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_RATIO) rdata = ratio_q;
        else if (addr == ADDR_KICK) begin
            rdata           = kick_q;
            rdata[KICK_BIT] = busy;
        end
    end
endmodule

// File: rtl/frc_update.sv
// Module: window counter plus pending/active ratio with kick handshake.
// Captures mult at an accepted kick, applies it at the window wrap and
// clears busy on that same edge.
module frc_update
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_req,
    input  logic [WIN_W-1:0]  code,
    output logic              busy,
    output logic              wrap,
    output logic [MULT_W-1:0] mult
);
    localparam logic [MULT_W-1:0] FULL = MULT_W'(1 << WIN_W);
    logic [WIN_W-1:0]  cnt_q;
    logic [MULT_W-1:0] pend_q;

    // Free-running position inside the 32-cycle window.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign wrap = (cnt_q == '1);

    // Kick capture, boundary apply and self-clear of busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pend_q <= FULL;
            mult   <= FULL;
        end else if (kick_req) begin
            busy   <= 1'b1;
            pend_q <= FULL - MULT_W'(code);
        end else if (busy && wrap) begin
            busy   <= 1'b0;
            mult   <= pend_q;
        end
    end

    // Counts how long busy has been held, for the latency check.
    logic [MULT_W:0] busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + 1'b1;
    end

    assert_busy_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= (MULT_W+1)'(1 << WIN_W));

    assert_switch_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mult != $past(mult)) |-> ($past(wrap) && $fell(busy)));

    assert_kick_ignored_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(pend_q));

    assert_mult_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mult >= 1) && (mult <= FULL));
endmodule

// File: rtl/frc_swallow.sv
// Module: phase accumulator that passes mult of every 32 cycles.
// Assumes mult changes only on the cycle after wrap; the accumulator
// restarts at zero there so each window holds exactly mult enables.
module frc_swallow
    import frc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic [MULT_W-1:0] mult,
    output logic              en
);
    logic [WIN_W-1:0] acc_q;
    logic [MULT_W:0]  sum;

    // Sum of phase and step; the carry bit marks a passed cycle.
    assign sum = {2'b00, acc_q} + {1'b0, mult};

    // Advance phase, restart at each window start, register the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            en    <= 1'b0;
        end else begin
            acc_q <= wrap ? '0 : sum[WIN_W-1:0];
            en    <= (sum >= (MULT_W+1)'(1 << WIN_W));
        end
    end

    assert_spread_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mult >= MULT_W'(16) && $past(mult) >= MULT_W'(16) && $past(rst_n) && !en)
        |-> $past(en));
endmodule

// File: rtl/frac_clk_kick.sv
// Module: top of the fractional clock enable generator.
// Connects the register bank, the update handshake and the swallower.
module frac_clk_kick
    import frc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        clk_en,
    output logic        busy
);
    logic [WIN_W-1:0]  code;
    logic              kick_req;
    logic              wrap;
    logic [MULT_W-1:0] mult;

    frc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .busy(busy), .rdata(reg_rdata),
        .code(code), .kick_req(kick_req)
    );

    frc_update u_upd (
        .clk(clk), .rst_n(rst_n), .kick_req(kick_req), .code(code),
        .busy(busy), .wrap(wrap), .mult(mult)
    );

    frc_swallow u_sw (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .mult(mult), .en(clk_en)
    );

    assert_kick_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_KICK && reg_wdata[KICK_BIT] && !busy) |=> busy);
endmodule

// File: tb/frac_clk_kick_bench.sv
module frac_clk_kick_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard entry: requirement tag and expected value.
    typedef struct { string tag; int unsigned val; } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    frac_clk_kick u_frac_clk_kick (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en), .busy(busy)
    );

    // Driver side: queue an expectation.
    task automatic expect_val(input string tag, input int unsigned v);
        exp_t e; e.tag = tag; e.val = v; exp_q.push_back(e);
    endtask

    // Monitor side: pop the oldest expectation and compare.
    task automatic observe(input int unsigned actual);
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (actual !== e.val) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, actual, e.val);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #0.5; d = reg_rdata;
    endtask

    // Count enables over 32 negedge samples; also count double lows.
    task automatic count_win(output int n, output int dbl);
        logic prev = 1'b1;
        n = 0; dbl = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (clk_en) n++;
            if (!clk_en && !prev) dbl++;
            prev = clk_en;
        end
    endtask

    // Poll busy at negedges; returns cycles seen high.
    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic kick_and_measure(input int code, input string tag);
        int lat, n, dbl;
        wr(2'd0, 32'h0000_0000 | (code << 8));
        wr(2'd1, 32'h8000_0000);
        wait_idle(lat);
        expect_val({tag, " R5 latency<=32"}, 1); observe(lat <= 32);
        count_win(n, dbl);
        expect_val({tag, " R7 first window"}, 32 - code); observe(n);
    endtask

    initial begin
        logic [31:0] d;
        int n, dbl, lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, d); expect_val("R1 ratio reset", 0); observe(d);
        rd(2'd1, d); expect_val("R1 kick reset", 0); observe(d);
        expect_val("R1 busy reset", 0); observe(busy);
        count_win(n, dbl); expect_val("R1 full rate", 32); observe(n);
        // R3 / R8 code write alone
        wr(2'd0, 32'h5A00_18A5);       // code 24, other bits set
        count_win(n, dbl); expect_val("R3 no effect without kick", 32); observe(n);
        rd(2'd0, d); expect_val("R8 ratio readback", 32'h5A00_18A5); observe(d);
        // R4 kick sets busy
        wr(2'd1, 32'h8000_1234);
        expect_val("R4 busy set", 1); observe(busy);
        rd(2'd1, d); expect_val("R4 kick bit reads 1", 32'h8000_1234); observe(d);
        wait_idle(lat); expect_val("R5 latency<=32", 1); observe(lat <= 32);
        count_win(n, dbl); expect_val("R7 first window mult 8", 8); observe(n);
        count_win(n, dbl); expect_val("R2 steady mult 8", 8); observe(n);
        rd(2'd1, d); expect_val("R8 kick bits kept", 32'h0000_1234); observe(d);
        rd(2'd0, d); expect_val("R8 ratio untouched", 32'h5A00_18A5); observe(d);
        // R6 busy ignores second kick
        wr(2'd0, 32'h0000_1000);        // code 16
        wr(2'd1, 32'h8000_0000);
        wr(2'd0, 32'h0000_0300);        // code 3
        wr(2'd1, 32'h8000_0000);        // ignored if still busy
        wait_idle(lat);
        count_win(n, dbl); expect_val("R6 first kick code used", 16); observe(n);
        expect_val("R9 no double low at mult 16", 0); observe(dbl);
        repeat (40) @(negedge clk);
        expect_val("R6 busy stays low", 0); observe(busy);
        count_win(n, dbl); expect_val("R6 second kick not applied", 16); observe(n);
        // R2 boundary codes
        kick_and_measure(31, "R2 mult 1");
        count_win(n, dbl); expect_val("R2 mult 1 steady", 1); observe(n);
        kick_and_measure(3, "R2 mult 29");
        count_win(n, dbl); expect_val("R9 no double low at mult 29", 0); observe(dbl);
        kick_and_measure(0, "R2 mult 32");
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule